// File: doc/BRIEF.md
# Network Controller Configuration Register Pair

This block holds two byte-wide configuration registers of a network controller, reached over a simple byte-addressed register bus. The control byte carries a driver-loaded flag, a wake-pin active-mode bit, a vital-product-data enable, a power-management enable and a two-bit LED select field. It also reflects two read-only mapping status inputs that show whether the operational registers sit in memory space or in I/O space. The mode byte is fixed and read-only: three mode bits always read 0, and a two-bit medium-type field always reads binary 10.

Several bits are coupled to other logic. A strobe from the PCI configuration decoder, raised when the command register's I/O, memory or bus-master enable bits are written, clears the driver-loaded flag. The power-management enable can be written only while an EEPROM-mode field is 11. That same enable turns the whole power-management capability on or off: it drives the new-capability status bit, the capability pointer, the capability ID, the next pointer and a valid flag for the PM registers. An EEPROM preload strobe loads the LED select field.

Top module: `nic_cfg_regs`

## Requirements
- R1: After asynchronous reset, the control byte reads 0 (with both mapping inputs low) and every capability output is 0.
- R2: A bus write to the control address stores bit 4 as the driver-loaded flag, and the flag reads back that value, 1 or 0.
- R3: A pulse on `cmd_en_wr_i` clears the driver-loaded flag on the next clock. It wins over a bus write to the flag in the same cycle.
- R4: Control bit 0 (PM enable) takes the written value only when `eem_i` is 2'b11. With any other `eem_i` value, a write leaves the bit unchanged while the other writable bits still update.
- R5: With PM enable at 1: `new_cap_o`=1, `cap_ptr_o`=CAP_PTR (default 8'h50), `cap_id_o`=CAP_ID (default 8'h01), `next_ptr_o`=0 and `pm_valid_o`=1.
- R6: With PM enable at 0: `new_cap_o`, `cap_ptr_o`, `cap_id_o`, `next_ptr_o` and `pm_valid_o` are all 0.
- R7: The mode byte (MODE_ADDR, default 8'h10) always reads 8'h02: bit 1 = 1, and bit 0 and bits 7..2 = 0. Writes to it have no effect.
- R8: Control bit 2 reads `io_map_i` and bit 3 reads `mem_map_i`. Writes to these bit positions have no effect.
- R9: LED select is control bits 7..6. It is written by the bus, and `ee_load_i` loads it from `ee_led_i` on the next clock. The load wins over a bus write in the same cycle.
- R10: Control bit 1 (VPD enable) and bit 5 (wake active mode) are plain read/write bits. Each resets to 0 and drives `vpd_en_o` and `wake_act_o`.
- R11: `rdata_o` is combinational from `addr_i`. An address other than CTL_ADDR (default 8'h11) or MODE_ADDR reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write enable |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| cmd_en_wr_i | input | 1 | PCI command enable bits written |
| eem_i | input | 2 | EEPROM-mode field; 2'b11 unlocks PM enable |
| ee_load_i | input | 1 | EEPROM preload strobe for LED select |
| ee_led_i | input | 2 | EEPROM preload value for LED select |
| io_map_i | input | 1 | Registers mapped in I/O space |
| mem_map_i | input | 1 | Registers mapped in memory space |
| new_cap_o | output | 1 | PCI status new-capability bit |
| cap_ptr_o | output | 8 | Capability pointer |
| cap_id_o | output | 8 | PM capability ID |
| next_ptr_o | output | 8 | PM next pointer |
| pm_valid_o | output | 1 | PM registers valid |
| led_sel_o | output | 2 | LED select |
| wake_act_o | output | 1 | Wake pin active mode |
| vpd_en_o | output | 1 | VPD enable |

## Verification
An all-ones write with the EEPROM-mode field locked separates the gated PM enable from the freely writable bits and the read-only mapping bits. Repeating the write unlocked shows that the gate, and not the data, decides the outcome. The command strobe is applied alone and together with a write that sets the driver flag, which shows its priority. The EEPROM preload is applied alone and together with a conflicting LED write. The capability outputs are compared in both PM states, and writes to the mode byte and reads of an unmapped address show that those bytes stay fixed.

// File: rtl/nic_cfg_pkg.sv
package nic_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int BIT_PM   = 0;
  localparam int BIT_VPD  = 1;
  localparam int BIT_IO   = 2;
  localparam int BIT_MEM  = 3;
  localparam int BIT_DRV  = 4;
  localparam int BIT_WAKE = 5;
  localparam int BIT_LED  = 6;
  localparam int LED_W    = 2;
  localparam logic [DATA_W-1:0] MODE_FIXED = 8'h02;

  typedef struct packed {
    logic [LED_W-1:0] led;
    logic             wake;
    logic             drv;
    logic             vpd;
    logic             pm;
  } ctl_state_t;
endpackage

// File: rtl/cfg_ctl_reg.sv
module cfg_ctl_reg
  import nic_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cmd_en_wr_i,
  input  logic [1:0]        eem_i,
  input  logic              ee_load_i,
  input  logic [LED_W-1:0]  ee_led_i,
  output ctl_state_t        state_o
);
  ctl_state_t q, d;
  logic sel_wr, pm_unlock;
  logic unused_wbits;

  assign sel_wr       = wr_en_i && (addr_i == CTL_ADDR);
  assign pm_unlock    = (eem_i == 2'b11);
  assign unused_wbits = ^{wdata_i[BIT_IO], wdata_i[BIT_MEM]};

  always_comb begin
    d = q;
    if (sel_wr) begin
      d.vpd  = wdata_i[BIT_VPD];
      d.drv  = wdata_i[BIT_DRV];
      d.wake = wdata_i[BIT_WAKE];
      d.led  = wdata_i[BIT_LED +: LED_W];
      if (pm_unlock) d.pm = wdata_i[BIT_PM];
    end
    if (cmd_en_wr_i) d.drv = 1'b0;   // hardware clear wins
    if (ee_load_i)   d.led = ee_led_i; // preload wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign state_o = q;

  assert_drv_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_wr_i |=> !state_o.drv);
  assert_drv_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CTL_ADDR && !cmd_en_wr_i) |=> state_o.drv == $past(wdata_i[BIT_DRV]));
  assert_pm_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eem_i != 2'b11) |=> $stable(state_o.pm));
  assert_led_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_load_i |=> state_o.led == $past(ee_led_i));
endmodule

// File: rtl/cfg_cap_gen.sv
module cfg_cap_gen #(
  parameter logic [7:0] CAP_PTR = 8'h50,
  parameter logic [7:0] CAP_ID  = 8'h01
) (
  input  logic       pm_en_i,
  output logic       new_cap_o,
  output logic [7:0] cap_ptr_o,
  output logic [7:0] cap_id_o,
  output logic [7:0] next_ptr_o,
  output logic       pm_valid_o
);
  always_comb begin
    new_cap_o  = pm_en_i;
    pm_valid_o = pm_en_i;
    cap_ptr_o  = pm_en_i ? CAP_PTR : 8'h00;
    cap_id_o   = pm_en_i ? CAP_ID  : 8'h00;
    next_ptr_o = 8'h00; // single capability in list
  end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import nic_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  ctl_state_t        state_i,
  input  logic              io_map_i,
  input  logic              mem_map_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctl_byte;

  always_comb begin
    ctl_byte                   = '0;
    ctl_byte[BIT_PM]           = state_i.pm;
    ctl_byte[BIT_VPD]          = state_i.vpd;
    ctl_byte[BIT_IO]           = io_map_i;
    ctl_byte[BIT_MEM]          = mem_map_i;
    ctl_byte[BIT_DRV]          = state_i.drv;
    ctl_byte[BIT_WAKE]         = state_i.wake;
    ctl_byte[BIT_LED +: LED_W] = state_i.led;
  end

  always_comb begin
    if (addr_i == CTL_ADDR)       rdata_o = ctl_byte;
    else if (addr_i == MODE_ADDR) rdata_o = MODE_FIXED;
    else                          rdata_o = '0;
  end
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h10,
  parameter logic [7:0] CAP_PTR = 8'h50,
  parameter logic [7:0] CAP_ID  = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              cmd_en_wr_i,
  input  logic [1:0]        eem_i,
  input  logic              ee_load_i,
  input  logic [1:0]        ee_led_i,
  input  logic              io_map_i,
  input  logic              mem_map_i,
  output logic              new_cap_o,
  output logic [7:0]        cap_ptr_o,
  output logic [7:0]        cap_id_o,
  output logic [7:0]        next_ptr_o,
  output logic              pm_valid_o,
  output logic [1:0]        led_sel_o,
  output logic              wake_act_o,
  output logic              vpd_en_o
);
  ctl_state_t st;

  cfg_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_ctl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .cmd_en_wr_i,
    .eem_i, .ee_load_i, .ee_led_i, .state_o(st)
  );

  cfg_cap_gen #(.CAP_PTR(CAP_PTR), .CAP_ID(CAP_ID)) u_cap (
    .pm_en_i(st.pm), .new_cap_o, .cap_ptr_o, .cap_id_o, .next_ptr_o, .pm_valid_o
  );

  cfg_rd_mux #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .MODE_ADDR(MODE_ADDR)) u_rd (
    .addr_i, .state_i(st), .io_map_i, .mem_map_i, .rdata_o
  );

  assign led_sel_o  = st.led;
  assign wake_act_o = st.wake;
  assign vpd_en_o   = st.vpd;

  assert_cap_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st.pm |-> (new_cap_o && pm_valid_o && cap_ptr_o == CAP_PTR && cap_id_o == CAP_ID && next_ptr_o == 8'h00));
  assert_cap_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st.pm |-> (!new_cap_o && !pm_valid_o && cap_ptr_o == 8'h00 && cap_id_o == 8'h00 && next_ptr_o == 8'h00));
  assert_mode_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == MODE_ADDR) |-> rdata_o == 8'h02);
endmodule

// File: tb/sim_nic_cfg_regs.sv
module sim_nic_cfg_regs;
  localparam logic [7:0] CTL  = 8'h11;
  localparam logic [7:0] MODE = 8'h10;

  typedef struct {
    string       tag;
    bit          is_cap;
    logic [25:0] exp;
  } item_t;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, cmd_wr = 0, ee_load = 0, io_map = 0, mem_map = 0;
  logic [7:0] addr = 0, wdata = 0, rdata, cap_ptr, cap_id, next_ptr;
  logic [1:0] eem = 0, ee_led = 0, led_sel;
  logic new_cap, pm_valid, wake_act, vpd_en;

  item_t sb[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  localparam logic [25:0] CAP_ON  = {1'b1, 1'b1, 8'h50, 8'h01, 8'h00};
  localparam logic [25:0] CAP_OFF = '0;

  always #5 clk = ~clk;

  nic_cfg_regs u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cmd_en_wr_i(cmd_wr), .eem_i(eem), .ee_load_i(ee_load), .ee_led_i(ee_led),
    .io_map_i(io_map), .mem_map_i(mem_map), .new_cap_o(new_cap), .cap_ptr_o(cap_ptr),
    .cap_id_o(cap_id), .next_ptr_o(next_ptr), .pm_valid_o(pm_valid),
    .led_sel_o(led_sel), .wake_act_o(wake_act), .vpd_en_o(vpd_en)
  );

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [25:0] act;
      it  = sb.pop_front();
      act = it.is_cap ? {new_cap, pm_valid, cap_ptr, cap_id, next_ptr} : {18'd0, rdata};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    addr = a;
    it.tag = tag; it.is_cap = 0; it.exp = {18'd0, e};
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expect_cap(input logic [25:0] e, input string tag);
    item_t it;
    it.tag = tag; it.is_cap = 1; it.exp = e;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  // one-cycle bus write with optional side strobes
  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic cmd, input logic ld);
    @(posedge clk); #1;
    wr_en = 1; addr = a; wdata = d; cmd_wr = cmd; ee_load = ld;
    @(posedge clk); #1;
    wr_en = 0; cmd_wr = 0; ee_load = 0;
  endtask

  task automatic strobe(input logic cmd, input logic ld);
    @(posedge clk); #1;
    cmd_wr = cmd; ee_load = ld;
    @(posedge clk); #1;
    cmd_wr = 0; ee_load = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1; #1;
    expect_rd(CTL, 8'h00, "R1 ctl reset");
    expect_cap(CAP_OFF, "R1 R6 cap reset");
    expect_rd(MODE, 8'h02, "R1 R7 mode reset");
    expect_rd(8'h05, 8'h00, "R11 unmapped");

    eem = 2'b00;
    bus_wr(CTL, 8'hFF, 0, 0);
    expect_rd(CTL, 8'hF2, "R4 R8 R2 R10 locked all-ones");
    expect_cap(CAP_OFF, "R4 pm locked");

    eem = 2'b11;
    bus_wr(CTL, 8'h01, 0, 0);
    expect_rd(CTL, 8'h01, "R4 R2 R10 unlocked pm write");
    expect_cap(CAP_ON, "R5 cap on");

    io_map = 1;
    expect_rd(CTL, 8'h05, "R8 io map input");
    mem_map = 1; io_map = 0;
    expect_rd(CTL, 8'h09, "R8 mem map input");
    mem_map = 0; io_map = 1;

    bus_wr(MODE, 8'hFF, 0, 0);
    expect_rd(MODE, 8'h02, "R7 mode write ignored");

    bus_wr(CTL, 8'h11, 0, 0);
    expect_rd(CTL, 8'h15, "R2 drv set");
    strobe(1, 0);
    expect_rd(CTL, 8'h05, "R3 cmd clear");
    bus_wr(CTL, 8'h11, 1, 0);
    expect_rd(CTL, 8'h05, "R3 clear beats write");

    bus_wr(CTL, 8'h00, 0, 0);
    expect_rd(CTL, 8'h04, "R6 pm off read");
    expect_cap(CAP_OFF, "R6 cap off");

    ee_led = 2'b01;
    strobe(0, 1);
    expect_rd(CTL, 8'h44, "R9 preload");
    ee_led = 2'b10;
    bus_wr(CTL, 8'hC0, 0, 1);
    expect_rd(CTL, 8'h84, "R9 preload beats write");
    bus_wr(CTL, 8'hC0, 0, 0);
    expect_rd(CTL, 8'hC4, "R9 sw led write");

    bus_wr(CTL, 8'h22, 0, 0);
    expect_rd(CTL, 8'h26, "R10 vpd wake set");

    eem = 2'b01;
    bus_wr(CTL, 8'h01, 0, 0);
    expect_rd(CTL, 8'h04, "R4 partial unlock ignored");

    addr = 8'hFF;
    expect_rd(8'hFF, 8'h00, "R11 unmapped high");

    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule